// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog timer that runs from a gated oscillator clock. It sits inside a larger clock and reset unit. It counts enabled clock cycles towards a timeout that software selects. If software does not service the watchdog before that timeout, the block raises a one-cycle reset request. It is disabled after reset and starts counting only when software writes a non-zero rate.

To service it, software writes the arm register twice: first 0x55, then 0xAA. Any other byte requests a reset at once. So does an 0xAA that does not follow a 0x55. An optional window mode accepts service writes only in the final quarter of the period; an earlier write is treated as a fault.

Stop-mode and wait-mode inputs can freeze the count, as set by two control bits. A two-bit cause output records what triggered the most recent reset request.

Top module: `wdog_keyseq`

## Requirements
- R1: After reset the watchdog is disabled, `rst_req` is 0 and `rst_cause` is 00. While the rate field is 000, no timeout occurs and arm-register writes are ignored.
- R2: Control byte layout: bits [2:0] rate, bit 3 window enable, bit 4 keep running in stop mode, bit 5 freeze in wait mode. For rate values 1 to 7 the period is 2^(BASE_LOG2+k) enabled cycles, where k is 0, 2, 4, 6, 8, 9 and 10 respectively.
- R3: When no service occurs, `rst_req` is high exactly one period of enabled cycles after the counter restarts, and `rst_cause` becomes 01.
- R4: Writing 0x55 and then 0xAA to the arm register restarts the counter from zero; the next timeout then comes one full period after the 0xAA write.
- R5: An arm write of any value other than 0x55 or 0xAA raises `rst_req` in the cycle after the write and sets `rst_cause` to 10.
- R6: An 0xAA arm write that does not directly follow an accepted 0x55 is a sequence error: it gives cause 10. Repeated 0x55 writes keep the checker waiting for 0xAA.
- R7: With window enable set, a 0x55 or 0xAA write while the count is below 3/4 of the period raises `rst_req` with `rst_cause` 11. From 3/4 onwards the write is accepted.
- R8: While `stop_mode` is high and control bit 4 is clear, the counter is frozen. With bit 4 set, the counter keeps running.
- R9: While `wait_mode` is high and control bit 5 is set, the counter is frozen. With bit 5 clear, `wait_mode` has no effect.
- R10: A control write restarts the counter from zero and discards a half-completed key sequence.
- R11: `rst_req` is a single-cycle registered pulse (timeout 01, key error 10, window 11). `rst_cause` holds its value until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gated oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 arm |
| wr_data | input | 8 | Write data byte |
| stop_mode | input | 1 | Chip is in stop mode |
| wait_mode | input | 1 | Chip is in wait mode |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Cause of last request |

## Verification
The assertions assume the following about the inputs:
- At most one register write happens per cycle, and `wr_sel` is valid whenever `wr_en` is high.
- The rate changes only through a control write, so the counter never holds a value outside the current period.
- `stop_mode` and `wait_mode` are synchronous levels.

The stimulus drives every input away from the active edge and keeps each write to a single cycle. After each expected reset request it disables the watchdog, so later timeouts never overlap the next test. In window mode it places the service write on the cycles just before and just at the three-quarter mark.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_TIMEOUT = 2'b01,
    CAUSE_KEY     = 2'b10,
    CAUSE_WINDOW  = 2'b11
  } cause_e;

  typedef struct packed {
    logic       wait_frz;
    logic       stop_run;
    logic       win_en;
    logic [2:0] rate;
  } ctrl_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam int unsigned MAX_EXTRA = 10;

  // extra doublings on top of the base stage for each rate code
  function automatic int unsigned rate_extra(input logic [2:0] r);
    case (r)
      3'd2:    return 2;
      3'd3:    return 4;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 9;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] wr_data,
  input  logic       stop_mode,
  input  logic       wait_mode,
  output ctrl_t      ctrl,
  output logic       tick_en
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wr_data[5:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  logic stop_gate, wait_gate;
  always_comb begin
    stop_gate = stop_mode && !ctrl_q.stop_run;
    wait_gate = wait_mode && ctrl_q.wait_frz;
    tick_en   = (ctrl_q.rate != 3'd0) && !stop_gate && !wait_gate;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       restart,
  input  logic [2:0] rate,
  output logic       timeout,
  output logic       in_window
);

  localparam int unsigned CW = BASE_LOG2 + MAX_EXTRA + 1;

  int unsigned     sh;
  logic [CW-1:0]   lim_m1, win_start;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    sh        = BASE_LOG2 + rate_extra(rate);
    lim_m1    = (CW'(1) << sh) - CW'(1);
    win_start = CW'(3) << (sh - 2);
  end

  always_comb begin
    timeout   = tick_en && (rate != 3'd0) && (cnt_q == lim_m1);
    in_window = cnt_q >= win_start;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)          cnt_d = '0;
    else if (tick_en) begin
      if (cnt_q >= lim_m1) cnt_d = '0;
      else                 cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // frozen clock leaves the count untouched
  p_frozen_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt_q));

  // the count never leaves the selected period
  p_count_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= lim_m1) || $past(restart));

endmodule

// File: rtl/wdog_keycheck.sv
module wdog_keycheck
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_wr,
  input  logic [7:0] wr_data,
  input  logic       enabled,
  input  logic       win_en,
  input  logic       in_window,
  input  logic       clear,
  output logic       service,
  output logic       bad_key,
  output logic       bad_window
);

  logic armed_q, armed_d;
  logic is_first, is_second;

  always_comb begin
    is_first   = (wr_data == KEY_FIRST);
    is_second  = (wr_data == KEY_SECOND);
    service    = 1'b0;
    bad_key    = 1'b0;
    bad_window = 1'b0;
    armed_d    = armed_q;
    if (arm_wr && enabled) begin
      if (!is_first && !is_second)   bad_key    = 1'b1;
      else if (win_en && !in_window) bad_window = 1'b1;
      else if (is_first)             armed_d    = 1'b1;
      else if (armed_q) begin
        service = 1'b1;
        armed_d = 1'b0;
      end else                       bad_key    = 1'b1;
    end
    if (clear || bad_key || bad_window) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // completion only after an accepted first key
  p_service_after_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    service |-> armed_q);

  p_single_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({service, bad_key, bad_window}));

endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       stop_mode,
  input  logic       wait_mode,
  output logic       rst_req,
  output logic [1:0] rst_cause
);

  ctrl_t  ctrl;
  logic   tick_en, timeout, in_window;
  logic   service, bad_key, bad_window;
  logic   ctrl_wr, arm_wr, enabled, tmo_hit, restart, clear;
  logic   req_q, req_d;
  cause_e cause_q, cause_d;

  always_comb begin
    ctrl_wr = wr_en && !wr_sel;
    arm_wr  = wr_en && wr_sel;
    enabled = ctrl.rate != 3'd0;
    tmo_hit = timeout && !service;
    restart = ctrl_wr || service || bad_key || bad_window;
    clear   = ctrl_wr || tmo_hit;
  end

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
    .stop_mode(stop_mode), .wait_mode(wait_mode),
    .ctrl(ctrl), .tick_en(tick_en)
  );

  wdog_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .rate(ctrl.rate), .timeout(timeout), .in_window(in_window)
  );

  wdog_keycheck u_key (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .wr_data(wr_data),
    .enabled(enabled), .win_en(ctrl.win_en), .in_window(in_window),
    .clear(clear), .service(service), .bad_key(bad_key),
    .bad_window(bad_window)
  );

  always_comb begin
    req_d   = tmo_hit || bad_key || bad_window;
    cause_d = cause_q;
    if (bad_key)         cause_d = CAUSE_KEY;
    else if (bad_window) cause_d = CAUSE_WINDOW;
    else if (tmo_hit)    cause_d = CAUSE_TIMEOUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign rst_req   = req_q;
  assign rst_cause = cause_q;

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !(timeout || bad_key || bad_window));

  p_req_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_cause != CAUSE_NONE));

  p_cause_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout || bad_key || bad_window) |=> $stable(rst_cause));

  p_window_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_window |-> ctrl.win_en);

endmodule

// File: tb/tb_wdog_keyseq.sv
module tb_wdog_keyseq;

  localparam int unsigned BASE = 4;
  localparam logic [1:0] C_TMO = 2'b01, C_KEY = 2'b10, C_WIN = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, stop_mode = 1'b0, wait_mode = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_req;
  logic [1:0] rst_cause;

  int cyc = 0, total = 0, bad = 0;
  int q_cyc[$];
  logic [1:0] q_cause[$];
  string q_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_keyseq #(.BASE_LOG2(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .rst_req(rst_req), .rst_cause(rst_cause)
  );

  // driver side: expected reset requests
  task automatic expect_req(input int c, input logic [1:0] cs, input string tag);
    q_cyc.push_back(c); q_cause.push_back(cs); q_tag.push_back(tag);
  endtask

  // monitor side: compares each observed pulse against the queue
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      total++;
      if (q_cyc.size() == 0) begin
        bad++;
        $display("FAIL unexpected request: cycle=%0d cause=%0b expected none", cyc, rst_cause);
      end else begin
        int ec; logic [1:0] ecs; string et;
        ec = q_cyc.pop_front(); ecs = q_cause.pop_front(); et = q_tag.pop_front();
        if (ec != cyc || ecs != rst_cause) begin
          bad++;
          $display("FAIL %s: request cycle=%0d cause=%0b expected cycle=%0d cause=%0b",
                   et, cyc, rst_cause, ec, ecs);
        end
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, output int e);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    e = cyc; wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    while (q_cyc.size() > 0) begin
      void'(q_cyc.pop_front()); void'(q_cause.pop_front());
      total++; bad++;
      $display("FAIL %s: request never seen, actual=none expected=pulse", q_tag.pop_front());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, s, c, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and disabled behaviour
    check_val("R1 reset rst_req", rst_req, 0);
    check_val("R1 reset cause", rst_cause, 0);
    wr(1'b1, 8'h12, e);
    wait_cyc(e + 100);
    check_val("R1 disabled arm write ignored", rst_cause, 0);

    // R2 R3 timeout for several rates
    wr(1'b0, 8'h01, e); expect_req(e + 16, C_TMO, "R3 rate1");
    wait_cyc(e + 16); wr(1'b0, 8'h00, x);
    check_val("R3 cause timeout", rst_cause, C_TMO);
    wr(1'b0, 8'h02, e); expect_req(e + 64, C_TMO, "R2 rate2");
    wait_cyc(e + 64); wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h03, e); expect_req(e + 256, C_TMO, "R2 rate3");
    wait_cyc(e + 256); wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h07, e); expect_req(e + 16384, C_TMO, "R2 rate7");
    wait_cyc(e + 16384); wr(1'b0, 8'h00, x);

    // R4 service
    wr(1'b0, 8'h02, e); wait_cyc(e + 30);
    wr(1'b1, 8'h55, x); wr(1'b1, 8'hAA, s);
    expect_req(s + 64, C_TMO, "R4 service restart");
    wait_cyc(s + 64); wr(1'b0, 8'h00, x);

    // R5 foreign value, R11 cause hold
    wr(1'b0, 8'h02, e); wait_cyc(e + 5);
    wr(1'b1, 8'h3C, s); expect_req(s, C_KEY, "R5 foreign value");
    wr(1'b0, 8'h00, x);
    wait_cyc(x + 20);
    check_val("R11 cause held", rst_cause, C_KEY);
    check_val("R11 pulse ended", rst_req, 0);

    // R6 lone second key, double first key
    wr(1'b0, 8'h02, e);
    wr(1'b1, 8'hAA, s); expect_req(s, C_KEY, "R6 lone second key");
    wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h02, e);
    wr(1'b1, 8'h55, x); wr(1'b1, 8'h55, x); wr(1'b1, 8'hAA, s);
    expect_req(s + 64, C_TMO, "R6 double first key");
    wait_cyc(s + 64); wr(1'b0, 8'h00, x);

    // R7 window boundary: count 47 rejected, 48 accepted
    wr(1'b0, 8'h0A, e); wait_cyc(e + 47);
    wr(1'b1, 8'h55, s); expect_req(s, C_WIN, "R7 early write");
    check_val("R7 early edge", s, e + 48);
    wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h0A, e); wait_cyc(e + 48);
    wr(1'b1, 8'h55, x); wr(1'b1, 8'hAA, s);
    expect_req(s + 64, C_TMO, "R7 in-window service");
    wait_cyc(s + 64); wr(1'b0, 8'h00, x);

    // R8 stop gating
    wr(1'b0, 8'h01, e); stop_mode = 1'b1; wait_cyc(e + 10); stop_mode = 1'b0;
    expect_req(e + 26, C_TMO, "R8 stop freezes");
    wait_cyc(e + 26); wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h11, e); stop_mode = 1'b1; wait_cyc(e + 10); stop_mode = 1'b0;
    expect_req(e + 16, C_TMO, "R8 stop runs");
    wait_cyc(e + 16); wr(1'b0, 8'h00, x);

    // R9 wait gating
    wr(1'b0, 8'h21, e); wait_mode = 1'b1; wait_cyc(e + 10); wait_mode = 1'b0;
    expect_req(e + 26, C_TMO, "R9 wait freezes");
    wait_cyc(e + 26); wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h01, e); wait_mode = 1'b1; wait_cyc(e + 10); wait_mode = 1'b0;
    expect_req(e + 16, C_TMO, "R9 wait ignored");
    wait_cyc(e + 16); wr(1'b0, 8'h00, x);

    // R10 control write restarts counter and drops partial key
    wr(1'b0, 8'h02, e); wait_cyc(e + 40);
    wr(1'b0, 8'h02, c); expect_req(c + 64, C_TMO, "R10 restart");
    wait_cyc(c + 64); wr(1'b0, 8'h00, x);
    wr(1'b0, 8'h02, e); wr(1'b1, 8'h55, x); wr(1'b0, 8'h02, c);
    wr(1'b1, 8'hAA, s); expect_req(s, C_KEY, "R10 key dropped");
    wr(1'b0, 8'h00, x);

    wait_cyc(x + 10);
    check_val("R1 idle at end", rst_req, 0);
    finish_run();
  end

endmodule